// File: doc/BRIEF.md
# Paged ROM Address Sequencer

This block produces the instruction ROM address of a small controller as a page number next to a word position within that page. The word position does not count in binary. Each instruction cycle moves it one step along a fixed 64-state shift-register sequence. The page changes only through a buffered page value, and that change takes effect when a jump is taken. Instruction decode drives one-cycle strobes into the block: load-page, branch, call and return. It also drives a condition bit and a jump target. The block answers with the address of the next instruction to fetch.

A taken call saves the return point and the current page, then enters call mode. While call mode is set, a taken jump can only move within the current page. Call mode holds one saved level, so a call made while in call mode acts as a short jump. All state moves only on cycles where the per-instruction enable is high. The control pins are plain level inputs sampled on those cycles. The block has no data stream, so there is no handshake and no back-pressure.

Top module: `rom_addr_seq`

## Requirements
- R1: After reset the address is page 15, word 0 (`rom_addr` = 10'h3C0, page in bits [9:6], word in bits [5:0]), the page buffer holds 15 and call mode is clear.
- R2: On an enabled cycle with no taken jump and no return, the page is kept. The word moves to its successor w' = {w[4:0], w[5]^w[4]^(w[4:0]==0)}. Starting from word 0, this visits all 64 words and comes back to 0 after 64 steps.
- R3: While `cyc_en` is low, the address and all internal state stay unchanged, whatever the strobes do.
- R4: `ld_page` writes `page_val` into the page buffer only. The page shown in `rom_addr` does not change because of it.
- R5: A branch with `status` high outside call mode loads `target` into the word and copies the page buffer into the page.
- R6: A branch or call with `status` low is not taken. The cycle acts as a plain step (R2).
- R7: A call with `status` high outside call mode jumps like R5. It saves the page in use and the successor of the current word (R2), then sets call mode.
- R8: A return in call mode restores the saved word and page and clears call mode. Return has priority over a branch or call in the same cycle.
- R9: In call mode, a taken branch or call loads `target` into the word and keeps the page. It also keeps the saved return point.
- R10: A return outside call mode is ignored: the cycle acts as if the strobe were absent.
- R11: When `ld_page` comes in the same cycle as a taken long jump, the jump uses the buffer value from before that cycle. The new value is used by the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One pulse per instruction cycle; all updates wait for it |
| ld_page | input | 1 | Write `page_val` into the page buffer |
| page_val | input | 4 | Page value for `ld_page` |
| br | input | 1 | Branch strobe |
| call | input | 1 | Call strobe |
| ret | input | 1 | Return strobe |
| status | input | 1 | Condition bit; high means a branch or call is taken |
| target | input | 6 | Word position of a branch or call |
| rom_addr | output | 10 | Registered ROM address {page, word} |

## Verification
The plain-step test walks the full 64-step word sequence from reset. It shows that the update is a single full-length cycle and not a shorter loop or a binary count. A sweep of long branches to every page with several targets shows whether the buffered page and the target reach the correct address fields. Taken and untaken branches and calls are mixed, inside and outside call mode, to show where status gates the jump and where call mode blocks the page change. Strobes with the enable low, returns outside call mode, and a page load in the same cycle as a jump show that each of these has no effect, or takes effect one cycle late as required.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

  typedef enum logic [2:0] {
    ACT_STEP   = 3'd0,
    ACT_LONG   = 3'd1,
    ACT_SHORT  = 3'd2,
    ACT_CALL   = 3'd3,
    ACT_RETURN = 3'd4
  } seq_act_e;

  // Feedback tap mask for a full-length shift register of the given width.
  // Bit k set means stage k feeds the XOR. Zero means no table entry.
  function automatic int unsigned seq_tap_mask(input int unsigned width);
    case (width)
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/seq_word_step.sv
module seq_word_step #(
  parameter int unsigned WORD_W = 6
) (
  input  logic [WORD_W-1:0] cur_word,
  output logic [WORD_W-1:0] nxt_word
);
  localparam int unsigned TAPS = rom_seq_pkg::seq_tap_mask(WORD_W);
  localparam logic [WORD_W-1:0] TAP_VEC = WORD_W'(TAPS);

  generate
    if (TAPS != 0) begin : g_shift
      logic low_zero;
      logic fb;
      always_comb begin
        low_zero = (cur_word[WORD_W-2:0] == '0);
        fb       = (^(cur_word & TAP_VEC)) ^ low_zero;
        nxt_word = {cur_word[WORD_W-2:0], fb};
      end
    end else begin : g_count
      always_comb nxt_word = cur_word + WORD_W'(1);
    end
  endgenerate
endmodule

// File: rtl/seq_page_regs.sv
module seq_page_regs #(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              buf_wr,
  input  logic [PAGE_W-1:0] buf_val,
  input  logic              take_buf,
  input  logic              restore,
  input  logic [PAGE_W-1:0] restore_val,
  output logic [PAGE_W-1:0] page,
  output logic [PAGE_W-1:0] page_buf
);
  localparam logic [PAGE_W-1:0] PAGE_RST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page     <= PAGE_RST;
      page_buf <= PAGE_RST;
    end else if (en) begin
      if (restore)       page <= restore_val;
      else if (take_buf) page <= page_buf;
      if (buf_wr)        page_buf <= buf_val;
    end
  end
endmodule

// File: rtl/seq_call_ctx.sv
module seq_call_ctx #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              enter,
  input  logic              leave,
  input  logic [WORD_W-1:0] save_word,
  input  logic [PAGE_W-1:0] save_page,
  output logic              in_call,
  output logic [WORD_W-1:0] ret_word,
  output logic [PAGE_W-1:0] ret_page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_call  <= 1'b0;
      ret_word <= '0;
      ret_page <= '0;
    end else if (en) begin
      if (enter) begin
        in_call  <= 1'b1;
        ret_word <= save_word;
        ret_page <= save_page;
      end else if (leave) begin
        in_call  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rom_addr_seq.sv
module rom_addr_seq #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned WORD_W = 6,
  localparam int unsigned ADDR_W = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              br,
  input  logic              call,
  input  logic              ret,
  input  logic              status,
  input  logic [WORD_W-1:0] target,
  output logic [ADDR_W-1:0] rom_addr
);
  import rom_seq_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] pbuf_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_nxt;
  logic              call_mode_q;
  logic [WORD_W-1:0] ret_word_q;
  logic [PAGE_W-1:0] ret_page_q;
  seq_act_e          act;

  seq_word_step #(.WORD_W(WORD_W)) u_step (
    .cur_word (word_q),
    .nxt_word (word_nxt)
  );

  // Return outranks call, call outranks branch; status gates any jump.
  always_comb begin
    act = ACT_STEP;
    if (ret && call_mode_q)
      act = ACT_RETURN;
    else if (call && status && !call_mode_q)
      act = ACT_CALL;
    else if ((call || br) && status)
      act = call_mode_q ? ACT_SHORT : ACT_LONG;
  end

  seq_page_regs #(.PAGE_W(PAGE_W)) u_page (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cyc_en),
    .buf_wr      (ld_page),
    .buf_val     (page_val),
    .take_buf    ((act == ACT_LONG) || (act == ACT_CALL)),
    .restore     (act == ACT_RETURN),
    .restore_val (ret_page_q),
    .page        (page_q),
    .page_buf    (pbuf_q)
  );

  seq_call_ctx #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cyc_en),
    .enter     (act == ACT_CALL),
    .leave     (act == ACT_RETURN),
    .save_word (word_nxt),
    .save_page (page_q),
    .in_call   (call_mode_q),
    .ret_word  (ret_word_q),
    .ret_page  (ret_page_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (cyc_en) begin
      case (act)
        ACT_LONG, ACT_SHORT, ACT_CALL: word_q <= target;
        ACT_RETURN:                    word_q <= ret_word_q;
        default:                       word_q <= word_nxt;
      endcase
    end
  end

  assign rom_addr = {page_q, word_q};
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned WORD_W = 6,
  localparam int unsigned ADDR_W = PAGE_W + WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_en,
  input logic              ld_page,
  input logic [PAGE_W-1:0] page_val,
  input logic              br,
  input logic              call,
  input logic              ret,
  input logic              status,
  input logic [WORD_W-1:0] target,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              call_mode,
  input logic [PAGE_W-1:0] page_buf
);
  logic [PAGE_W-1:0] pg;
  logic [WORD_W-1:0] wd;
  assign pg = rom_addr[ADDR_W-1:WORD_W];
  assign wd = rom_addr[WORD_W-1:0];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(rom_addr) && $stable(call_mode) && $stable(page_buf))); // R3

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !br && !call && !ret) |=> ($stable(pg) && (wd != $past(wd)))); // R2

  AST_LDP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ld_page && !br && !call && !ret) |=> ($stable(pg) && (page_buf == $past(page_val)))); // R4

  AST_LONG_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !call_mode && br && status && !call && !ret) |=>
      (rom_addr == {$past(page_buf), $past(target)})); // R5

  AST_UNTAKEN_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && (br || call) && !status && !ret) |=> ($stable(pg) && $stable(call_mode))); // R6

  AST_CALL_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !call_mode && call && status && !ret) |=> call_mode); // R7

  AST_RET_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && call_mode && ret) |=> !call_mode); // R8

  AST_SHORT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && call_mode && (br || call) && status && !ret) |=>
      ($stable(pg) && call_mode && (wd == $past(target)))); // R9

  AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !call_mode && ret && !br && !call) |=> ($stable(pg) && !call_mode)); // R10
endmodule

bind rom_addr_seq seq_checker #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_en    (cyc_en),
  .ld_page   (ld_page),
  .page_val  (page_val),
  .br        (br),
  .call      (call),
  .ret       (ret),
  .status    (status),
  .target    (target),
  .rom_addr  (rom_addr),
  .call_mode (call_mode_q),
  .page_buf  (pbuf_q)
);

// File: tb/tb_rom_addr_seq.sv
module tb_rom_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ld_page = 1'b0, br = 1'b0, call = 1'b0, ret = 1'b0, status = 1'b0;
  logic [3:0] page_val = '0;
  logic [5:0] target = '0;
  logic [9:0] rom_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model of the architectural state.
  logic [3:0] m_page = 4'hF, m_pb = 4'hF, m_rp = '0;
  logic [5:0] m_word = '0, m_rw = '0;
  logic       m_cl = 1'b0;

  always #4 clk = ~clk;

  rom_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ld_page(ld_page), .page_val(page_val),
    .br(br), .call(call), .ret(ret), .status(status), .target(target), .rom_addr(rom_addr)
  );

  // Successor from R2: shift left, feedback from bits 5 and 4, flipped when bits 4..0 are zero.
  function automatic logic [5:0] succ(input logic [5:0] w);
    logic fb;
    fb = w[5] ^ w[4];
    if (w[4:0] == 5'd0) fb = ~fb;
    return {w[4:0], fb};
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rom_addr=%h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic ldp, input logic [3:0] pv,
                     input logic b, input logic c, input logic r, input logic st,
                     input logic [5:0] tg, input string req);
    logic [3:0] np, npb, nrp;
    logic [5:0] nw, nrw;
    logic       ncl;
    @(negedge clk);
    cyc_en = en; ld_page = ldp; page_val = pv; br = b; call = c; ret = r; status = st; target = tg;
    np = m_page; npb = m_pb; nrp = m_rp; nw = m_word; nrw = m_rw; ncl = m_cl;
    if (en) begin
      nw = succ(m_word);
      if (r && m_cl) begin
        nw = m_rw; np = m_rp; ncl = 1'b0;
      end else if (c && st && !m_cl) begin
        nrw = succ(m_word); nrp = m_page; nw = tg; np = m_pb; ncl = 1'b1;
      end else if ((b || c) && st) begin
        nw = tg;
        if (!m_cl) np = m_pb;
      end
      if (ldp) npb = pv;
    end
    m_page = np; m_pb = npb; m_rp = nrp; m_word = nw; m_rw = nrw; m_cl = ncl;
    @(posedge clk);
    #1;
    check(req, rom_addr, {m_page, m_word});
  endtask

  task automatic step(input string req);
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: rom_addr=%h expected run to finish", rom_addr);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit [63:0] seen;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset address", rom_addr, 10'h3C0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after release", rom_addr, 10'h3C0);

    // R2: walk the full sequence.
    seen = '0;
    seen[0] = 1'b1;
    for (int i = 0; i < 64; i++) begin
      step("R2 plain step");
      seen[rom_addr[5:0]] = 1'b1;
    end
    check("R2 back to word 0 after 64", rom_addr, 10'h3C0);
    check("R2 all 64 words visited", 10'($countones(seen)), 10'd64);

    // R3: strobes with enable low.
    cyc(1'b0, 1'b1, 4'h3, 1'b1, 1'b0, 1'b0, 1'b1, 6'h2A, "R3 idle branch");
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h11, "R3 idle call");
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h05, "R3 buffer untouched while idle");
    check("R3 page still 15", {6'd0, rom_addr[9:6]}, 10'd15);

    // R4: load page alone does not move the page.
    cyc(1'b1, 1'b1, 4'h6, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, "R4 load page");
    step("R4 page unchanged");
    step("R4 page unchanged 2");

    // R5: long branch to every page with several targets.
    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 64; t += 21) begin
        cyc(1'b1, 1'b1, 4'(p), 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, "R4 load before branch");
        cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 6'(t), "R5 long branch");
        check("R5 branch lands", rom_addr, {4'(p), 6'(t)});
      end
    end

    // R6: untaken branch and call.
    cyc(1'b1, 1'b1, 4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, "R4 load");
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h33, "R6 untaken branch");
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h12, "R6 untaken call");

    // R7/R9/R8: call, short jumps, return.
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h21, "R7 call lands");
    check("R7 call uses buffer page", {6'd0, rom_addr[9:6]}, 10'd9);
    step("R7 step inside call");
    cyc(1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, "R9 load in call mode");
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h3E, "R9 short branch keeps page");
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h07, "R9 nested call is short");
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 6'h15, "R8 return beats branch");
    check("R8 return page restored", {6'd0, rom_addr[9:6]}, 10'd15);

    // R10: return outside call mode.
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h0, "R10 stray return");
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 6'h0C, "R10 stray return with branch");

    // R11: load page in same cycle as a long branch.
    cyc(1'b1, 1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, "R4 load");
    cyc(1'b1, 1'b1, 4'hB, 1'b1, 1'b0, 1'b0, 1'b1, 6'h19, "R11 branch uses old buffer");
    check("R11 old page taken", {6'd0, rom_addr[9:6]}, 10'd4);
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h2D, "R11 next branch uses new buffer");
    check("R11 new page taken", {6'd0, rom_addr[9:6]}, 10'd11);

    // R7: return point after a call from a known word.
    cyc(1'b1, 1'b1, 4'h1, 1'b0, 1'b1, 1'b0, 1'b1, 6'h00, "R7 call with same-cycle load");
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h0, "R8 return");
    check("R7 saved successor", rom_addr, {4'hB, succ(6'h2D)});

    // R1: reset again mid-run.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", rom_addr, 10'h3C0);
    m_page = 4'hF; m_pb = 4'hF; m_word = '0; m_cl = 1'b0; m_rw = '0; m_rp = '0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h0A, "R1 buffer reset to 15");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule